// File: doc/BRIEF.md
# Multi-Channel Wiper Position Register with Serial Step Mode

This block holds one 8-bit position code for each of several potentiometer channels. Code 00h places the wiper nearest the low terminal and FFh places it nearest the high terminal. The block drives the decoded code straight to the resistor-array selector, which sits outside this block. Each channel has four stored data registers. Their contents come in on a flat input bus. After reset, each channel takes its position from its own stored register 0.

A decoded command port changes the positions. It can write a host byte into one channel, copy one stored register into one channel, or copy the same stored register index into every channel at once. A step command selects one channel and puts the block into step mode. In step mode, every rising edge of the serial clock moves that channel by one position. The level of the serial data line picks the direction: high moves toward the high terminal and low moves toward the low terminal. Stepping saturates at both ends. Step mode ends when chip select goes high.

The serial clock, data and chip-select lines are asynchronous to the system clock. Each is brought in through a two-stage synchronizer. The controller is a three-state machine. BOOT is the single cycle after reset, in which every channel loads stored register 0; it then moves to IDLE. IDLE accepts commands; a step command moves it to STEP. STEP applies one step per serial-clock rise and returns to IDLE as soon as the synchronized chip select is seen high.

Top module: `wiper_bank`

## Requirements
- R1: While reset is asserted, every position reads 00h. At the first clock edge after reset is released, channel c takes stored register 0 of channel c. Stored register r of channel c sits at `dreg_i[(c*4+r)*8 +: 8]`.
- R2: Op code 1 (write) with `cmd_valid_i` high in IDLE loads `cmd_data_i` into channel `cmd_chan_i` at the next clock edge. Other channels are unchanged.
- R3: Op code 2 (load) in IDLE copies stored register `cmd_reg_i` of channel `cmd_chan_i` into that channel. Other channels are unchanged.
- R4: Op code 3 (load all) in IDLE copies stored register `cmd_reg_i` of each channel into that same channel, for all channels in the same cycle.
- R5: Op code 4 (step) in IDLE enters STEP for channel `cmd_chan_i`. While in STEP, each rising edge of `sck_i` adds one to the position if `sdi_i` is 1, or subtracts one if `sdi_i` is 0. The change shows three clock edges after the input edge.
- R6: A step up at FFh leaves FFh. A step down at 00h leaves 00h. The position never wraps.
- R7: Only the channel named by the step command moves in STEP. All other channels hold their values.
- R8: STEP ends once the synchronized `cs_n_i` is high. Rising edges of `sck_i` outside STEP have no effect. Commands presented while in STEP are ignored.
- R9: Op codes 0, 5, 6 and 7 change nothing. Any op code with `cmd_valid_i` low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_op_i | input | 3 | Op code: 1 write, 2 load, 3 load all, 4 step |
| cmd_chan_i | input | 2 | Target channel |
| cmd_reg_i | input | 2 | Stored register index |
| cmd_data_i | input | 8 | Host byte for write |
| dreg_i | input | 128 | Stored register contents, channel-major |
| sck_i | input | 1 | Serial clock (asynchronous) |
| sdi_i | input | 1 | Serial data level, gives step direction |
| cs_n_i | input | 1 | Chip select, active low (asynchronous) |
| pos_o | output | 32 | Position codes, channel c at bits [c*8 +: 8] |

## Verification
A command-port load appears on `pos_o` one edge after the strobe. A serial clock edge, or chip select going high, acts only after two synchronizer edges plus the register edge, so three edges after the input. The bench holds `sdi_i` stable for three cycles before each `sck_i` rise and keeps each level of `sck_i` for four cycles. The scoreboard monitor then samples six falling edges after each expectation is posted, which is well past every due cycle. The ignore cases are observed on the full position vector before the next stimulus.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_IDLE = 2'd1,
        ST_STEP = 2'd2
    } ctl_state_t;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_WRITE    = 3'd1,
        OP_LOAD     = 3'd2,
        OP_LOAD_ALL = 3'd3,
        OP_STEP     = 3'd4
    } op_t;

endpackage

// File: rtl/wcs_sync.sv
module wcs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= {STAGES{RST_VAL}};
        else        shift_q <= {shift_q[STAGES-2:0], d_i};
    end

    assign q_o = shift_q[STAGES-1];
endmodule

// File: rtl/wcs_chan.sv
module wcs_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_en_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         step_en_i,
    input  logic         step_up_i,
    output logic [W-1:0] pos_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] MINV = '0;

    logic [W-1:0] pos_q, pos_d;

    always_comb begin
        pos_d = pos_q;
        if (ld_en_i) begin
            pos_d = ld_val_i;
        end else if (step_en_i) begin
            if (step_up_i && pos_q != MAXV)       pos_d = pos_q + W'(1);
            else if (!step_up_i && pos_q != MINV) pos_d = pos_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign pos_o = pos_q;

    // R6: saturate at the top
    a_r6_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !ld_en_i && step_up_i && pos_q == MAXV) |=> pos_q == MAXV);
    // R6: saturate at the bottom
    a_r6_hold_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !ld_en_i && !step_up_i && pos_q == MINV) |=> pos_q == MINV);
    // R5: one step up
    a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !ld_en_i && step_up_i && pos_q != MAXV) |=> pos_q == W'($past(pos_q) + 1'b1));
    // R5: one step down
    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !ld_en_i && !step_up_i && pos_q != MINV) |=> pos_q == W'($past(pos_q) - 1'b1));
    // R7/R9: with no load and no step the position holds
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en_i && !ld_en_i) |=> $stable(pos_q));
endmodule

// File: rtl/wcs_ctrl.sv
module wcs_ctrl
    import wcs_pkg::*;
#(
    parameter int NCH = 4,
    parameter int NDR = 4,
    parameter int W   = 8,
    localparam int CW = $clog2(NCH),
    localparam int RW = $clog2(NDR)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid_i,
    input  logic [2:0]     cmd_op_i,
    input  logic [CW-1:0]  cmd_chan_i,
    input  logic [RW-1:0]  cmd_reg_i,
    input  logic           sck_rise_i,
    input  logic           sdi_s_i,
    input  logic           cs_hi_i,
    output logic [NCH-1:0] ld_en_o,
    output logic           ld_host_o,
    output logic [RW-1:0]  ld_reg_o,
    output logic [NCH-1:0] step_en_o,
    output logic           step_up_o
);
    ctl_state_t    state_q, state_d;
    logic [CW-1:0] chan_q, chan_d;
    logic          cmd_ok;

    assign cmd_ok = cmd_valid_i && (int'(cmd_chan_i) < NCH);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            chan_q  <= '0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        chan_d  = chan_q;
        unique case (state_q)
            ST_BOOT: state_d = ST_IDLE;
            ST_IDLE: begin
                if (cmd_ok && op_t'(cmd_op_i) == OP_STEP) begin
                    state_d = ST_STEP;
                    chan_d  = cmd_chan_i;
                end
            end
            ST_STEP: if (cs_hi_i) state_d = ST_IDLE;
            default: state_d = ST_BOOT;
        endcase
    end

    // outputs
    always_comb begin
        ld_en_o   = '0;
        ld_host_o = 1'b0;
        ld_reg_o  = '0;
        step_en_o = '0;
        step_up_o = sdi_s_i;
        unique case (state_q)
            ST_BOOT: ld_en_o = '1;
            ST_IDLE: begin
                if (cmd_valid_i) begin
                    unique case (op_t'(cmd_op_i))
                        OP_WRITE: begin
                            if (cmd_ok) ld_en_o[cmd_chan_i] = 1'b1;
                            ld_host_o = 1'b1;
                        end
                        OP_LOAD: begin
                            if (cmd_ok) ld_en_o[cmd_chan_i] = 1'b1;
                            ld_reg_o = cmd_reg_i;
                        end
                        OP_LOAD_ALL: begin
                            ld_en_o  = '1;
                            ld_reg_o = cmd_reg_i;
                        end
                        default: ;
                    endcase
                end
            end
            ST_STEP: if (!cs_hi_i && sck_rise_i) step_en_o[chan_q] = 1'b1;
            default: ;
        endcase
    end

    // R1: boot lasts one cycle and leads to IDLE
    a_r1_boot_once: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_BOOT |=> state_q == ST_IDLE);
    // R7: at most one channel steps
    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_en_o));
    // R8: chip select high leaves step mode
    a_r8_cs_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && cs_hi_i) |=> state_q == ST_IDLE);
    // R8: no load while stepping
    a_r8_no_load_in_step: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STEP |-> ld_en_o == '0);
    // R5: step command moves into STEP
    a_r5_enter_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_ok && cmd_op_i == 3'd4) |=> state_q == ST_STEP);
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
    parameter int NCH   = 4,
    parameter int NDR   = 4,
    parameter int W     = 8,
    parameter int SYNCN = 2,
    localparam int CW   = $clog2(NCH),
    localparam int RW   = $clog2(NDR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid_i,
    input  logic [2:0]         cmd_op_i,
    input  logic [CW-1:0]      cmd_chan_i,
    input  logic [RW-1:0]      cmd_reg_i,
    input  logic [W-1:0]       cmd_data_i,
    input  logic [NCH*NDR*W-1:0] dreg_i,
    input  logic               sck_i,
    input  logic               sdi_i,
    input  logic               cs_n_i,
    output logic [NCH*W-1:0]   pos_o
);
    logic sck_s, sdi_s, cs_s, sck_q, sck_rise;
    logic [NCH-1:0] ld_en, step_en;
    logic           ld_host, step_up;
    logic [RW-1:0]  ld_reg;

    wcs_sync #(.STAGES(SYNCN), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .d_i(sck_i), .q_o(sck_s));
    wcs_sync #(.STAGES(SYNCN), .RST_VAL(1'b0)) u_sync_sdi (
        .clk(clk), .rst_n(rst_n), .d_i(sdi_i), .q_o(sdi_s));
    wcs_sync #(.STAGES(SYNCN), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d_i(cs_n_i), .q_o(cs_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end
    assign sck_rise = sck_s & ~sck_q;

    wcs_ctrl #(.NCH(NCH), .NDR(NDR), .W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
        .cmd_chan_i(cmd_chan_i), .cmd_reg_i(cmd_reg_i),
        .sck_rise_i(sck_rise), .sdi_s_i(sdi_s), .cs_hi_i(cs_s),
        .ld_en_o(ld_en), .ld_host_o(ld_host), .ld_reg_o(ld_reg),
        .step_en_o(step_en), .step_up_o(step_up));

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [W-1:0] ld_val;
        assign ld_val = ld_host ? cmd_data_i : dreg_i[(c*NDR + int'(ld_reg))*W +: W];

        wcs_chan #(.W(W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .ld_en_i(ld_en[c]), .ld_val_i(ld_val),
            .step_en_i(step_en[c]), .step_up_i(step_up),
            .pos_o(pos_o[c*W +: W]));
    end

    // R1: during reset every position reads zero
    a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> pos_o == '0);
endmodule

// File: tb/test_wiper_bank.sv
module test_wiper_bank;
    localparam int NCH = 4, NDR = 4, W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_chan = 2'd0, cmd_reg = 2'd0;
    logic [7:0] cmd_data = 8'd0;
    logic [NCH*NDR*W-1:0] dreg;
    logic sck = 1'b0, sdi = 1'b0, cs_n = 1'b1;
    logic [NCH*W-1:0] pos;

    int checks = 0, errors = 0, pending = 0;
    logic [7:0] model [NCH];
    logic [NCH*W-1:0] qpos[$];
    string qreq[$];

    always #5 clk = ~clk;

    wiper_bank i_wiper_bank (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_chan_i(cmd_chan), .cmd_reg_i(cmd_reg), .cmd_data_i(cmd_data),
        .dreg_i(dreg), .sck_i(sck), .sdi_i(sdi), .cs_n_i(cs_n), .pos_o(pos));

    function automatic logic [7:0] dval(int c, int r);
        return 8'(c*64 + r*17 + 5);
    endfunction

    function automatic logic [NCH*W-1:0] snap();
        logic [NCH*W-1:0] v;
        for (int c = 0; c < NCH; c++) v[c*W +: W] = model[c];
        return v;
    endfunction

    task automatic check(logic [NCH*W-1:0] exp, string req);
        checks++;
        if (pos !== exp) begin
            errors++;
            $display("FAIL %s: pos=%h expected=%h", req, pos, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_now(string req);
        qpos.push_back(snap());
        qreq.push_back(req);
        pending++;
        wait (pending == 0);
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            wait (pending > 0);
            repeat (6) @(negedge clk);
            check(qpos.pop_front(), qreq.pop_front());
            pending--;
        end
    end

    task automatic cmd(logic [2:0] op, int ch, int rg, logic [7:0] d, logic v = 1'b1);
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_chan = 2'(ch); cmd_reg = 2'(rg); cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic pulse(logic up);
        @(negedge clk); sdi = up;
        repeat (3) @(negedge clk);
        sck = 1'b1;
        repeat (4) @(negedge clk);
        sck = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [7:0] stepv(logic [7:0] v, logic up);
        if (up) return (v == 8'hFF) ? v : v + 8'd1;
        return (v == 8'h00) ? v : v - 8'd1;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++)
            for (int r = 0; r < NDR; r++) dreg[(c*NDR + r)*W +: W] = dval(c, r);
        for (int c = 0; c < NCH; c++) model[c] = 8'h00;
        repeat (3) @(negedge clk);
        check('0, "R1 reset");
        rst_n = 1'b1;
        for (int c = 0; c < NCH; c++) model[c] = dval(c, 0);
        expect_now("R1 boot");

        cmd(3'd1, 2, 0, 8'h7E); model[2] = 8'h7E; expect_now("R2 write");
        cmd(3'd2, 1, 3, 8'h00); model[1] = dval(1, 3); expect_now("R3 load");
        cmd(3'd3, 0, 2, 8'h00);
        for (int c = 0; c < NCH; c++) model[c] = dval(c, 2);
        expect_now("R4 load all");

        cmd(3'd0, 0, 0, 8'h11); expect_now("R9 op0");
        cmd(3'd5, 1, 1, 8'h22); expect_now("R9 op5");
        cmd(3'd6, 2, 1, 8'h33); expect_now("R9 op6");
        cmd(3'd7, 3, 1, 8'h44); expect_now("R9 op7");
        cmd(3'd1, 0, 0, 8'h55, 1'b0); expect_now("R9 no valid");

        cmd(3'd1, 0, 0, 8'hFD); model[0] = 8'hFD; expect_now("R2 write ch0");
        cs_n = 1'b0;
        cmd(3'd4, 0, 0, 8'h00);
        for (int i = 0; i < 3; i++) begin
            pulse(1'b1); model[0] = stepv(model[0], 1'b1);
            expect_now(i < 2 ? "R5 step up" : "R6 top saturate");
        end
        cmd(3'd1, 1, 0, 8'h00); expect_now("R8 cmd ignored in step");
        pulse(1'b0); model[0] = stepv(model[0], 1'b0); expect_now("R7 only ch0 steps");
        @(negedge clk); cs_n = 1'b1;
        repeat (5) @(negedge clk);
        pulse(1'b1); pulse(1'b0); expect_now("R8 after cs high");

        cmd(3'd1, 3, 0, 8'h01); model[3] = 8'h01; expect_now("R2 write ch3");
        cs_n = 1'b0;
        cmd(3'd4, 3, 0, 8'h00);
        pulse(1'b0); model[3] = 8'h00; expect_now("R5 step down");
        pulse(1'b0); expect_now("R6 bottom saturate");
        pulse(1'b1); model[3] = 8'h01; expect_now("R5 step up ch3");
        @(negedge clk); cs_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n = 1'b0;
        pulse(1'b1); pulse(1'b1); expect_now("R8 no step without command");
        cs_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule